// File: doc/BRIEF.md
# Key-Protected Data Word Store Controller

This block manages a small nonvolatile-style store of 16-bit words. A host reaches it over a plain register bus with four registers: a control word, a write-only key, an address, and a data port. The data port holds the value to be programmed and, when read, returns the stored word at the current address. Program and erase commands are honoured only in the single cycle that follows a correct two-write unlock on the key register. Any other attempt is refused and raises an error flag.

An accepted operation runs in the background for a fixed number of cycles, set by a parameter. The start bit reads back as busy for that whole time, and the bus is never held off. The store sits at the top of its address space, so only the highest `DEPTH` word addresses are implemented. Reads elsewhere return zero, and commands aimed elsewhere are rejected.

Top module: `dee_keyed_ctrl`

## Requirements
- R1: After reset the control register and the address register read 0, and every implemented word reads FFFFh.
- R2: Register offsets are 0 for control, 1 for key, 2 for address and 3 for data. Writing a key value with low byte 55h, then one with low byte AAh, opens the control register for the next cycle only. A control write in that cycle is accepted: it loads the operation field (bits 1:0) and clears the error (bit 14) and done (bit 13) flags.
- R3: The unlock sequence restarts in two cases: a key byte other than the expected one, or any bus access between the 55h and AAh writes. A control write made while locked changes nothing, except that a write with bit 15 set raises the error flag.
- R4: If the cycle after the AAh write passes with no control write, the control register is locked again.
- R5: An accepted start (bit 15 set) with operation code 01 writes the data register value into the word at the address register.
- R6: An accepted start with operation code 10 sets the addressed word to FFFFh.
- R7: Bit 15 reads 1 for exactly LATENCY cycles after the start is accepted. It then clears by itself and the done flag is set.
- R8: While an operation is busy, the word being changed reads its old contents, and every register stays accessible without stall. The captured data is the value that gets committed.
- R9: A start attempt while busy, whether locked or unlocked, raises the error flag and leaves the running operation unchanged.
- R10: An address below 2^ADDR_W − DEPTH reads as 0 on the data port. A program or erase to such an address raises the error flag and writes no word, including no aliased word.
- R11: An unlocked start with operation code 00 or 11 raises the error flag and writes nothing.
- R12: The key register always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 2 | Register select (0 control, 1 key, 2 address, 3 data) |
| bus_wdata | input | 16 | Write value |
| bus_rdata | output | 16 | Read value of the selected register, combinational |

## Verification
A table of program and erase commands is applied at the lowest implemented word, the highest one, and a middle one. These include an erase after a program and a program over a zero. A wrong data path, a wrong index, or a swapped operation code each gives a different read-back. The key sequence is tried four ways: intact, broken by a read, broken by a wrong byte, and left to lapse for one idle cycle. This separates a correct single-cycle window from one that is too loose. The busy window is checked for read-back of the old word, bus writes without stall, start attempts while busy, and the bit-15 edge exactly at LATENCY cycles. Out-of-range addresses are chosen so that their low bits alias an implemented word, which exposes any missing range check.

// File: rtl/dee_pkg.sv
package dee_pkg;

    localparam int unsigned WORD_W = 16;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_KEY  = 2'd1,
        REG_ADDR = 2'd2,
        REG_DATA = 2'd3
    } dee_reg_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_RSVD  = 2'b11
    } dee_op_e;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_HALF = 2'd1,
        UL_OPEN = 2'd2
    } dee_ul_e;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

endpackage

// File: rtl/dee_unlock.sv
module dee_unlock
    import dee_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_valid,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       open
);

    typedef struct packed {
        dee_ul_e st;
    } ul_state_t;

    ul_state_t ul_d, ul_q;

    always_comb begin
        ul_d = ul_q;
        unique case (ul_q.st)
            UL_IDLE: begin
                if (acc_valid && key_wr && key_byte == KEY_FIRST)
                    ul_d.st = UL_HALF;
            end
            UL_HALF: begin
                // any access at all here either completes or breaks the pair
                if (acc_valid)
                    ul_d.st = (key_wr && key_byte == KEY_SECOND) ? UL_OPEN : UL_IDLE;
            end
            UL_OPEN: begin
                // window lives one cycle; a fresh first key may restart the pair
                ul_d.st = (acc_valid && key_wr && key_byte == KEY_FIRST) ? UL_HALF : UL_IDLE;
            end
            default: ul_d.st = UL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ul_q <= '{st: UL_IDLE};
        else        ul_q <= ul_d;
    end

    assign open = (ul_q.st == UL_OPEN);

endmodule

// File: rtl/dee_seq.sv
module dee_seq
    import dee_pkg::*;
#(
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned LATENCY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              wr_req,
    input  logic [1:0]        op_req,
    input  logic              open,
    input  logic              addr_ok,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] latch,
    output logic [WORD_W-1:0] ctrl_word,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [WORD_W-1:0] commit_data
);

    localparam int unsigned CNT_W = $clog2(LATENCY + 1);

    typedef struct packed {
        logic              busy;
        logic              err;
        logic              done;
        logic [1:0]        op;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } seq_state_t;

    seq_state_t sq_d, sq_q;
    logic       last_cycle;
    logic       op_legal;

    assign last_cycle = sq_q.busy && (sq_q.cnt == CNT_W'(1));
    assign op_legal   = (op_req == OP_PROG) || (op_req == OP_ERASE);

    always_comb begin
        sq_d = sq_q;

        if (sq_q.busy) begin
            if (last_cycle) begin
                sq_d.busy = 1'b0;
                sq_d.done = 1'b1;
                sq_d.cnt  = '0;
            end else begin
                sq_d.cnt = sq_q.cnt - CNT_W'(1);
            end
        end

        if (ctrl_wr) begin
            if (!open || sq_q.busy) begin
                if (wr_req) sq_d.err = 1'b1;
            end else begin
                sq_d.op   = op_req;
                sq_d.err  = 1'b0;
                sq_d.done = 1'b0;
                if (wr_req) begin
                    if (addr_ok && op_legal) begin
                        sq_d.busy = 1'b1;
                        sq_d.cnt  = CNT_W'(LATENCY);
                        sq_d.idx  = idx;
                        sq_d.data = (op_req == OP_ERASE) ? {WORD_W{1'b1}} : latch;
                    end else begin
                        sq_d.err = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign ctrl_word   = {sq_q.busy, sq_q.err, sq_q.done, 11'b0, sq_q.op};
    assign commit      = last_cycle;
    assign commit_idx  = sq_q.idx;
    assign commit_data = sq_q.data;

endmodule

// File: rtl/dee_array.sv
module dee_array
    import dee_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem_d [DEPTH];
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[widx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= {WORD_W{1'b1}};
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[ridx];

endmodule

// File: rtl/dee_keyed_ctrl.sv
module dee_keyed_ctrl
    import dee_pkg::*;
#(
    parameter int unsigned DEPTH   = 256,
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned LATENCY = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [1:0]  bus_reg,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata
);

    localparam int unsigned IDX_W  = $clog2(DEPTH);
    localparam int unsigned SPAN   = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(SPAN - DEPTH);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] latch;
    } bus_state_t;

    bus_state_t rg_d, rg_q;

    logic              ul_open;
    logic [7:0]        key_byte;
    logic              wr_req;
    logic [1:0]        op_req;
    logic              key_wr, ctrl_wr;
    logic              addr_ok;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  cur_idx;
    logic [WORD_W-1:0] ctrl_word;
    logic              seq_commit;
    logic [IDX_W-1:0]  seq_idx;
    logic [WORD_W-1:0] seq_data;
    logic [WORD_W-1:0] arr_rd;

    assign key_byte = bus_wdata[7:0];
    assign wr_req   = bus_wdata[15];
    assign op_req   = bus_wdata[1:0];
    assign key_wr   = bus_valid && bus_write && (bus_reg == REG_KEY);
    assign ctrl_wr  = bus_valid && bus_write && (bus_reg == REG_CTRL);
    assign addr_q   = rg_q.addr;
    assign addr_ok  = (rg_q.addr >= BASE);
    assign cur_idx  = rg_q.addr[IDX_W-1:0];

    always_comb begin
        rg_d = rg_q;
        if (bus_valid && bus_write) begin
            if (bus_reg == REG_ADDR) rg_d.addr  = bus_wdata[ADDR_W-1:0];
            if (bus_reg == REG_DATA) rg_d.latch = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    dee_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (bus_valid),
        .key_wr    (key_wr),
        .key_byte  (key_byte),
        .open      (ul_open)
    );

    dee_seq #(
        .IDX_W   (IDX_W),
        .LATENCY (LATENCY)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .wr_req      (wr_req),
        .op_req      (op_req),
        .open        (ul_open),
        .addr_ok     (addr_ok),
        .idx         (cur_idx),
        .latch       (rg_q.latch),
        .ctrl_word   (ctrl_word),
        .commit      (seq_commit),
        .commit_idx  (seq_idx),
        .commit_data (seq_data)
    );

    dee_array #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (seq_commit),
        .widx  (seq_idx),
        .wdata (seq_data),
        .ridx  (cur_idx),
        .rdata (arr_rd)
    );

    always_comb begin
        unique case (bus_reg)
            REG_CTRL: bus_rdata = ctrl_word;
            REG_KEY:  bus_rdata = '0;
            REG_ADDR: bus_rdata = 16'(rg_q.addr);
            default:  bus_rdata = addr_ok ? arr_rd : '0;
        endcase
    end

endmodule

// File: rtl/dee_keyed_ctrl_chk.sv
module dee_keyed_ctrl_chk #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [1:0]        bus_reg,
    input logic [7:0]        key_byte,
    input logic              wr_req,
    input logic [15:0]       bus_rdata,
    input logic [ADDR_W-1:0] addr_q,
    input logic              open,
    input logic              commit,
    input logic [15:0]       ctrl_word
);

    localparam int unsigned SPAN = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LOW_EDGE = ADDR_W'(SPAN - DEPTH);

    logic start_try;
    assign start_try = bus_valid && bus_write && (bus_reg == 2'd0) && wr_req;

    // R2
    open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open |-> $past(bus_valid && bus_write && bus_reg == 2'd1 && key_byte == 8'hAA));

    // R4
    window_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open |=> !open);

    // R3
    locked_start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_try && !open) |=> ctrl_word[14]);

    // R7
    done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_word[15]) |-> ctrl_word[13]);

    // R8
    commit_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ctrl_word[15]);

    // R9
    busy_start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_try && ctrl_word[15]) |=> ctrl_word[14]);

    // R10
    oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reg == 2'd3 && addr_q < LOW_EDGE) |-> bus_rdata == 16'h0000);

    // R12
    key_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reg == 2'd1) |-> bus_rdata == 16'h0000);

endmodule

bind dee_keyed_ctrl dee_keyed_ctrl_chk #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_reg   (bus_reg),
    .key_byte  (key_byte),
    .wr_req    (wr_req),
    .bus_rdata (bus_rdata),
    .addr_q    (addr_q),
    .open      (ul_open),
    .commit    (seq_commit),
    .ctrl_word (ctrl_word)
);

// File: tb/tb_dee_keyed_ctrl.sv
module tb_dee_keyed_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 8;
    localparam logic [1:0] R_CTRL = 2'd0, R_KEY = 2'd1, R_ADDR = 2'd2, R_DATA = 2'd3;

    // {addr, data, op, expected word}
    localparam logic [49:0] VECS [0:5] = '{
        {16'hFF00, 16'h1234, 2'b01, 16'h1234},
        {16'hFFFF, 16'hA5A5, 2'b01, 16'hA5A5},
        {16'hFF80, 16'h0000, 2'b01, 16'h0000},
        {16'hFF00, 16'h0000, 2'b10, 16'hFFFF},
        {16'hFF80, 16'h5A5A, 2'b01, 16'h5A5A},
        {16'hFF7F, 16'h00FF, 2'b01, 16'h00FF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_reg = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    dee_keyed_ctrl #(.DEPTH(256), .ADDR_W(16), .LATENCY(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [1:0] r, input logic [15:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_reg = r; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] r, output logic [15:0] v);
        bus_valid = 1'b1; bus_write = 1'b0; bus_reg = r;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic unlock();
        acc(R_KEY, 16'h0055);
        acc(R_KEY, 16'h00AA);
    endtask

    task automatic clear_flags(input logic [1:0] op);
        unlock();
        acc(R_CTRL, {14'h0, op});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state, R10 default address is out of range, R12 key reads zero
        rd(R_CTRL, rv); check("R1 ctrl after reset", rv, 16'h0000);
        rd(R_ADDR, rv); check("R1 addr after reset", rv, 16'h0000);
        rd(R_DATA, rv); check("R10 read below range", rv, 16'h0000);
        rd(R_KEY,  rv); check("R12 key reads zero", rv, 16'h0000);
        acc(R_ADDR, 16'hFF40);
        rd(R_DATA, rv); check("R1 erased word after reset", rv, 16'hFFFF);

        // R2 R5 R6 R7 table of operations
        for (int i = 0; i < 6; i++) begin
            acc(R_ADDR, VECS[i][49:34]);
            acc(R_DATA, VECS[i][33:18]);
            unlock();
            acc(R_CTRL, {14'h2000, VECS[i][17:16]});
            rd(R_CTRL, rv); check("R7 busy after start", rv & 16'h8000, 16'h8000);
            idle(LAT - 2);
            rd(R_CTRL, rv); check("R7 busy in last cycle", rv & 16'h8000, 16'h8000);
            rd(R_CTRL, rv); check("R7 done after latency", rv, {14'h0800, VECS[i][17:16]});
            rd(R_DATA, rv); check("R5 R6 word after op", rv, VECS[i][15:0]);
        end

        // R3 sequence broken by a read
        acc(R_ADDR, 16'hFF00);
        acc(R_DATA, 16'h4444);
        acc(R_KEY, 16'h0055);
        rd(R_ADDR, rv);
        acc(R_KEY, 16'h00AA);
        acc(R_CTRL, 16'h8001);
        rd(R_CTRL, rv); check("R3 broken by read: err, not busy", rv & 16'hC000, 16'h4000);
        idle(LAT);
        rd(R_DATA, rv); check("R3 broken by read: word kept", rv, 16'hFFFF);

        // R3 wrong second byte
        acc(R_KEY, 16'h0055);
        acc(R_KEY, 16'h0056);
        acc(R_KEY, 16'h00AA);
        acc(R_CTRL, 16'h8001);
        idle(LAT);
        rd(R_DATA, rv); check("R3 wrong byte: word kept", rv, 16'hFFFF);

        // R2 accepted plain write clears flags
        clear_flags(2'b01);
        rd(R_CTRL, rv); check("R2 unlocked write clears flags", rv, 16'h0001);

        // R3 locked write without start bit changes nothing
        acc(R_CTRL, 16'h0002);
        rd(R_CTRL, rv); check("R3 locked write ignored", rv, 16'h0001);

        // R4 window lapses after one idle cycle
        unlock();
        idle(1);
        acc(R_CTRL, 16'h8001);
        rd(R_CTRL, rv); check("R4 lapsed window: err", rv & 16'hC000, 16'h4000);
        idle(LAT);
        rd(R_DATA, rv); check("R4 lapsed window: word kept", rv, 16'hFFFF);
        clear_flags(2'b01);

        // R8 old contents visible during busy, no stall on bus writes
        acc(R_ADDR, 16'hFF20);
        acc(R_DATA, 16'h1111);
        unlock();
        acc(R_CTRL, 16'h8001);
        rd(R_DATA, rv); check("R8 old word during busy", rv, 16'hFFFF);
        acc(R_DATA, 16'h2222);
        idle(LAT);
        rd(R_DATA, rv); check("R8 captured data committed", rv, 16'h1111);

        // R9 start attempts while busy
        acc(R_ADDR, 16'hFF21);
        acc(R_DATA, 16'h3333);
        unlock();
        acc(R_CTRL, 16'h8001);
        acc(R_CTRL, 16'h8002);
        rd(R_CTRL, rv); check("R9 locked start while busy: err", rv & 16'hC000, 16'hC000);
        unlock();
        acc(R_CTRL, 16'h8002);
        rd(R_CTRL, rv); check("R9 unlocked start while busy: err", rv & 16'hC003, 16'hC001);
        idle(LAT);
        rd(R_DATA, rv); check("R9 running program unchanged", rv, 16'h3333);
        clear_flags(2'b01);

        // R10 out-of-range reads and commands
        acc(R_ADDR, 16'hFEFF);
        rd(R_DATA, rv); check("R10 read below range", rv, 16'h0000);
        acc(R_DATA, 16'h7777);
        unlock();
        acc(R_CTRL, 16'h8001);
        rd(R_CTRL, rv); check("R10 program rejected", rv & 16'hC000, 16'h4000);
        acc(R_ADDR, 16'h00FF);
        unlock();
        acc(R_CTRL, 16'h8002);
        rd(R_CTRL, rv); check("R10 erase rejected", rv & 16'hC000, 16'h4000);
        idle(LAT);
        acc(R_ADDR, 16'hFFFF);
        rd(R_DATA, rv); check("R10 aliased word untouched", rv, 16'hA5A5);
        clear_flags(2'b01);

        // R11 reserved operation codes
        acc(R_ADDR, 16'hFF00);
        acc(R_DATA, 16'h9999);
        unlock();
        acc(R_CTRL, 16'h8000);
        rd(R_CTRL, rv); check("R11 code 00 rejected", rv & 16'hC000, 16'h4000);
        unlock();
        acc(R_CTRL, 16'h8003);
        rd(R_CTRL, rv); check("R11 code 11 rejected", rv & 16'hC000, 16'h4000);
        idle(LAT);
        rd(R_DATA, rv); check("R11 word kept", rv, 16'hFFFF);

        // R5 a valid start after an error clears the flag and programs
        unlock();
        acc(R_CTRL, 16'h8001);
        idle(LAT);
        rd(R_CTRL, rv); check("R5 error cleared, done set", rv, 16'h2001);
        rd(R_DATA, rv); check("R5 word programmed", rv, 16'h9999);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule